// File: doc/BRIEF.md
# Two-Plane Program and Erase Queue

This block sits behind a flash bus front end that has already separated command bytes from address bytes. It collects the row address of each program or erase request, works out which of the two planes the request targets, and either parks the request in a per-plane slot or, on the closing confirm code, fires every parked plane together with the one just addressed. The launch appears as a one-cycle pulse per plane towards the array engines, carrying each plane's block and page number, and a simple countdown stands in for the array's busy time.

A program request may start a fresh sequence or continue a multi-plane one. A fresh program setup tells the page buffers of both planes to drop their contents; a setup that follows a queued program does not. Queue confirms hold the block busy only for a short, separate count before the next plane's request can be taken.

Top module: `nmq_plane_queue`

## Requirements
- R1: The plane is bit 0 of the block number; the row address holds the page number in its low PAGE_W bits and the block number in the next BLK_W bits.
- R2: A program closed with code 11h stores the block and page in that plane's slot, raises that plane's `queued` bit, launches nothing, and holds `busy` high for exactly QBUSY_CYC cycles.
- R3: A program closed with code 10h pulses `launch_prog` for one cycle on every plane that is queued plus the addressed plane, with each plane's stored (or new) block and page on `launch_block`/`launch_page` in that cycle.
- R4: An erase (setup 60h) closed with D1h queues the addressed plane; one closed with D0h pulses `launch_erase` on every queued plane plus the addressed one.
- R5: A program setup 80h accepted while no program is queued pulses `cache_clr` for one cycle and empties the queue; an 80h accepted while a program is queued leaves `cache_clr` low and the queue intact.
- R6: A queue confirm naming a plane that is already queued replaces that plane's block and page.
- R7: A closing confirm naming a plane that is already queued launches with the closing address, not the queued one.
- R8: After a launch the queue is empty (`queued` = 00) and `busy` stays high for exactly ARRAY_CYC cycles.
- R9: Commands presented while `busy` is high are ignored: no pulse and no change of `queued`.
- R10: After 80h the first COL_CYC address bytes (column) are discarded and the next ROW_CYC bytes form the row address, least significant byte first; after 60h all ROW_CYC bytes are row bytes.
- R11: An erase setup 60h accepted while programs are queued drops those queued programs, so a following D0h launches only the erase plane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_code | input | 8 | Command byte |
| addr_valid | input | 1 | Address byte strobe |
| addr_byte | input | 8 | Address byte |
| busy | output | 1 | Queue or array busy |
| queued | output | 2 | Per-plane pending flag |
| cache_clr | output | 1 | One-cycle pulse: clear both page buffers' valid flags |
| launch_prog | output | 2 | Per-plane program start pulse |
| launch_erase | output | 2 | Per-plane erase start pulse |
| launch_block | output | 2×BLK_W | Per-plane block number at launch |
| launch_page | output | 2×PAGE_W | Per-plane page number at launch |

## Verification
The bench builds the block with QBUSY_CYC = 3 and ARRAY_CYC = 8 while keeping the default 6-bit page, 11-bit block and two-column, three-row address layout. The short busy counts make it practical to count every busy cycle exactly, both after queue confirms and after launches, and to fire commands inside the busy window. Keeping the real address layout means the column bytes are genuinely discarded and the plane bit lands in the middle of the first row byte.

// File: rtl/nmq_pkg.sv
package nmq_pkg;
  typedef enum logic {ST_IDLE, ST_COLLECT} nmq_state_e;
  typedef enum logic {OP_PROG, OP_ERASE} nmq_op_e;
  localparam logic [7:0] CMD_PROG_SETUP = 8'h80;
  localparam logic [7:0] CMD_PROG_QUEUE = 8'h11;
  localparam logic [7:0] CMD_PROG_GO    = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
  localparam logic [7:0] CMD_ERASE_QUEUE = 8'hD1;
  localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
endpackage

// File: rtl/nmq_row_asm.sv
module nmq_row_asm #(
  parameter int COL_CYC = 2,
  parameter int ROW_CYC = 3,
  parameter int OUT_W   = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             skip_col,
  input  logic             byte_en,
  input  logic [7:0]       byte_in,
  output logic [OUT_W-1:0] row,
  output logic             done
);
  localparam int TOT = COL_CYC + ROW_CYC;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0]    cnt_q, cnt_d, lim_q, lim_d, skip_q, skip_d;
  logic [OUT_W-1:0] row_q, row_d;
  logic [CW-1:0]    idx;

  assign done = (cnt_q == lim_q);
  assign row  = row_q;
  assign idx  = cnt_q - skip_q;

  always_comb begin
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    skip_d = skip_q;
    row_d  = row_q;
    if (start) begin
      cnt_d  = '0;
      skip_d = skip_col ? CW'(COL_CYC) : '0;
      lim_d  = skip_col ? CW'(TOT) : CW'(ROW_CYC);
      row_d  = '0;
    end else if (byte_en && !done) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q >= skip_q) begin
        for (int b = 0; b < OUT_W; b++) begin
          if (idx == CW'(b / 8)) row_d[b] = byte_in[b % 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lim_q  <= '0;
      skip_q <= '0;
      row_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      lim_q  <= lim_d;
      skip_q <= skip_d;
      row_q  <= row_d;
    end
  end

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= lim_q);
endmodule

// File: rtl/nmq_busy_timer.sv
module nmq_busy_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          busy
);
  logic [CW-1:0] cnt_q, cnt_d;

  assign busy = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_load_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);
endmodule

// File: rtl/nmq_plane_slot.sv
module nmq_plane_slot #(
  parameter int BLK_W  = 11,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              clr,
  input  logic [BLK_W-1:0]  blk_in,
  input  logic [PAGE_W-1:0] pg_in,
  output logic              pend,
  output logic [BLK_W-1:0]  blk,
  output logic [PAGE_W-1:0] pg
);
  logic              pend_d;
  logic [BLK_W-1:0]  blk_d;
  logic [PAGE_W-1:0] pg_d;

  always_comb begin
    pend_d = pend;
    blk_d  = blk;
    pg_d   = pg;
    if (clr) begin
      pend_d = 1'b0;
    end else if (wr) begin
      pend_d = 1'b1;
      blk_d  = blk_in;
      pg_d   = pg_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      blk  <= '0;
      pg   <= '0;
    end else begin
      pend <= pend_d;
      blk  <= blk_d;
      pg   <= pg_d;
    end
  end

  assert_write_sets_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (pend && blk == $past(blk_in)));
endmodule

// File: rtl/nmq_plane_queue.sv
module nmq_plane_queue
  import nmq_pkg::*;
#(
  parameter int PAGE_W    = 6,
  parameter int BLK_W     = 11,
  parameter int COL_CYC   = 2,
  parameter int ROW_CYC   = 3,
  parameter int QBUSY_CYC = 4,
  parameter int ARRAY_CYC = 20
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cmd_valid,
  input  logic [7:0]                  cmd_code,
  input  logic                        addr_valid,
  input  logic [7:0]                  addr_byte,
  output logic                        busy,
  output logic [1:0]                  queued,
  output logic                        cache_clr,
  output logic [1:0]                  launch_prog,
  output logic [1:0]                  launch_erase,
  output logic [1:0][BLK_W-1:0]       launch_block,
  output logic [1:0][PAGE_W-1:0]      launch_page
);
  localparam int ROW_W = PAGE_W + BLK_W;
  localparam int MAXC  = (QBUSY_CYC > ARRAY_CYC) ? QBUSY_CYC : ARRAY_CYC;
  localparam int CW    = $clog2(MAXC + 1);

  nmq_state_e st_q, st_d;
  nmq_op_e    kind_q, kind_d, qkind_q, qkind_d;

  logic             row_start, row_skip, row_done;
  logic [ROW_W-1:0] row;
  logic [BLK_W-1:0] row_blk;
  logic [PAGE_W-1:0] row_pg;
  logic             plane;

  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic [1:0]       slot_wr;
  logic             slot_clr;
  logic [1:0][BLK_W-1:0]  slot_blk;
  logic [1:0][PAGE_W-1:0] slot_pg;

  logic                   cclr_d;
  logic [1:0]             lp_d, le_d;
  logic [1:0][BLK_W-1:0]  lb_d;
  logic [1:0][PAGE_W-1:0] lg_d;

  assign row_blk = row[PAGE_W +: BLK_W];
  assign row_pg  = row[PAGE_W-1:0];
  assign plane   = row_blk[0];

  nmq_row_asm #(.COL_CYC(COL_CYC), .ROW_CYC(ROW_CYC), .OUT_W(ROW_W)) u_row (
    .clk(clk), .rst_n(rst_n), .start(row_start), .skip_col(row_skip),
    .byte_en(addr_valid && st_q == ST_COLLECT), .byte_in(addr_byte),
    .row(row), .done(row_done));

  nmq_busy_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(busy));

  for (genvar p = 0; p < 2; p++) begin : g_slot
    nmq_plane_slot #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_slot (
      .clk(clk), .rst_n(rst_n), .wr(slot_wr[p]), .clr(slot_clr),
      .blk_in(row_blk), .pg_in(row_pg),
      .pend(queued[p]), .blk(slot_blk[p]), .pg(slot_pg[p]));
  end

  always_comb begin
    st_d      = st_q;
    kind_d    = kind_q;
    qkind_d   = qkind_q;
    row_start = 1'b0;
    row_skip  = 1'b0;
    tmr_load  = 1'b0;
    tmr_val   = '0;
    slot_wr   = '0;
    slot_clr  = 1'b0;
    cclr_d    = 1'b0;
    lp_d      = '0;
    le_d      = '0;
    lb_d      = slot_blk;
    lg_d      = slot_pg;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid && !busy) begin
          if (cmd_code == CMD_PROG_SETUP) begin
            st_d = ST_COLLECT; kind_d = OP_PROG;
            row_start = 1'b1; row_skip = 1'b1;
            if (!(|queued && qkind_q == OP_PROG)) begin
              slot_clr = 1'b1;
              cclr_d   = 1'b1;
            end
          end else if (cmd_code == CMD_ERASE_SETUP) begin
            st_d = ST_COLLECT; kind_d = OP_ERASE;
            row_start = 1'b1;
            if (|queued && qkind_q != OP_ERASE) slot_clr = 1'b1;
          end
        end
      end
      default: begin
        if (cmd_valid) begin
          st_d = ST_IDLE;
          if (row_done) begin
            if ((kind_q == OP_PROG  && cmd_code == CMD_PROG_QUEUE) ||
                (kind_q == OP_ERASE && cmd_code == CMD_ERASE_QUEUE)) begin
              slot_wr[plane] = 1'b1;
              qkind_d  = kind_q;
              tmr_load = 1'b1;
              tmr_val  = CW'(QBUSY_CYC);
            end else if ((kind_q == OP_PROG  && cmd_code == CMD_PROG_GO) ||
                         (kind_q == OP_ERASE && cmd_code == CMD_ERASE_GO)) begin
              lb_d[plane] = row_blk;
              lg_d[plane] = row_pg;
              if (kind_q == OP_PROG) begin
                lp_d = queued; lp_d[plane] = 1'b1;
              end else begin
                le_d = queued; le_d[plane] = 1'b1;
              end
              slot_clr = 1'b1;
              tmr_load = 1'b1;
              tmr_val  = CW'(ARRAY_CYC);
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_IDLE;
      kind_q       <= OP_PROG;
      qkind_q      <= OP_PROG;
      cache_clr    <= 1'b0;
      launch_prog  <= '0;
      launch_erase <= '0;
      launch_block <= '0;
      launch_page  <= '0;
    end else begin
      st_q         <= st_d;
      kind_q       <= kind_d;
      qkind_q      <= qkind_d;
      cache_clr    <= cclr_d;
      launch_prog  <= lp_d;
      launch_erase <= le_d;
      launch_block <= lb_d;
      launch_page  <= lg_d;
    end
  end

  assert_launch_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|launch_prog || |launch_erase) |-> (queued == 2'b00 && busy));
  assert_single_kind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(|launch_prog && |launch_erase));
  assert_clr_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cache_clr |-> (queued == 2'b00 && !busy));
  assert_busy_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy) |-> $stable(queued));
  assert_launch_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    |launch_prog |=> launch_prog == 2'b00);
endmodule

// File: tb/nmq_plane_queue_test.sv
module nmq_plane_queue_test;
  localparam int PW = 6, BW = 11, QB = 3, AC = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_valid, addr_valid;
  logic [7:0] cmd_code, addr_byte;
  logic busy, cache_clr;
  logic [1:0] queued, launch_prog, launch_erase;
  logic [1:0][BW-1:0] launch_block;
  logic [1:0][PW-1:0] launch_page;
  int n_run = 0, n_fail = 0;

  always #5 clk = ~clk;

  nmq_plane_queue #(.PAGE_W(PW), .BLK_W(BW), .COL_CYC(2), .ROW_CYC(3),
                    .QBUSY_CYC(QB), .ARRAY_CYC(AC)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .addr_valid(addr_valid), .addr_byte(addr_byte), .busy(busy),
    .queued(queued), .cache_clr(cache_clr), .launch_prog(launch_prog),
    .launch_erase(launch_erase), .launch_block(launch_block),
    .launch_page(launch_page));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [7:0] c);
    cmd_valid = 1'b1; cmd_code = c;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic abyte(input logic [7:0] b);
    addr_valid = 1'b1; addr_byte = b;
    @(negedge clk);
    addr_valid = 1'b0;
  endtask

  task automatic row(input int blk, input int pg, input bit with_col);
    logic [23:0] r;
    r = 24'((blk << PW) | pg);
    if (with_col) begin abyte(8'hA5); abyte(8'h5A); end
    abyte(r[7:0]); abyte(r[15:8]); abyte(r[23:16]);
  endtask

  task automatic busy_for(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      chk(busy === 1'b1, req, busy, 1);
      @(negedge clk);
    end
    chk(busy === 1'b0, req, busy, 0);
  endtask

  task automatic prog(input int blk, input int pg, input logic [7:0] conf);
    cmd(8'h80); row(blk, pg, 1'b1); cmd(conf);
  endtask

  task automatic t_reset;
    chk(busy === 0 && queued === 0 && cache_clr === 0, "R8 reset", {busy, queued, cache_clr}, 0);
    chk(launch_prog === 0 && launch_erase === 0, "R3 reset", {launch_prog, launch_erase}, 0);
  endtask

  task automatic t_single;
    cmd(8'h80);
    chk(cache_clr === 1'b1, "R5 fresh setup clears", cache_clr, 1);
    row(5, 3, 1'b1); cmd(8'h10);
    chk(launch_prog === 2'b10, "R1 plane from block bit0", launch_prog, 2);
    chk(launch_block[1] === 11'd5 && launch_page[1] === 6'd3, "R10 column skipped",
        {launch_block[1], launch_page[1]}, {11'd5, 6'd3});
    chk(queued === 2'b00, "R8 empty after launch", queued, 0);
    busy_for(AC, "R8 array busy");
    chk(launch_prog === 2'b00, "R3 one-cycle pulse", launch_prog, 0);
  endtask

  task automatic t_two_prog;
    prog(8, 7, 8'h11);
    chk(queued === 2'b01 && launch_prog === 2'b00, "R2 queue only", {queued, launch_prog}, 4);
    busy_for(QB, "R2 short busy");
    cmd(8'h80);
    chk(cache_clr === 1'b0 && queued === 2'b01, "R5 chained setup keeps", {cache_clr, queued}, 1);
    row(9, 7, 1'b1); cmd(8'h10);
    chk(launch_prog === 2'b11, "R3 both planes", launch_prog, 3);
    chk(launch_block[0] === 11'd8 && launch_block[1] === 11'd9, "R3 blocks",
        {launch_block[0], launch_block[1]}, {11'd8, 11'd9});
    busy_for(AC, "R8 busy two-plane");
  endtask

  task automatic t_erase;
    cmd(8'h60); row(20, 0, 1'b0); cmd(8'hD1);
    chk(queued === 2'b01 && launch_erase === 2'b00, "R4 erase queued", queued, 1);
    busy_for(QB, "R4 queue busy");
    cmd(8'h60); row(33, 0, 1'b0); cmd(8'hD0);
    chk(launch_erase === 2'b11 && launch_prog === 2'b00, "R4 erase both", launch_erase, 3);
    chk(launch_block[0] === 11'd20 && launch_block[1] === 11'd33, "R10 erase row only",
        {launch_block[0], launch_block[1]}, {11'd20, 11'd33});
    busy_for(AC, "R4 erase busy");
  endtask

  task automatic t_replace;
    prog(2, 1, 8'h11); busy_for(QB, "R6 busy a");
    prog(4, 2, 8'h11); busy_for(QB, "R6 busy b");
    chk(queued === 2'b01, "R6 one slot", queued, 1);
    prog(7, 5, 8'h10);
    chk(launch_block[0] === 11'd4 && launch_page[0] === 6'd2, "R6 replaced",
        {launch_block[0], launch_page[0]}, {11'd4, 6'd2});
    chk(launch_block[1] === 11'd7 && launch_page[1] === 6'd5, "R3 plane1 new",
        {launch_block[1], launch_page[1]}, {11'd7, 6'd5});
    busy_for(AC, "R8 busy c");
  endtask

  task automatic t_override;
    prog(10, 1, 8'h11); busy_for(QB, "R7 busy a");
    prog(12, 9, 8'h10);
    chk(launch_prog === 2'b01, "R7 same plane only", launch_prog, 1);
    chk(launch_block[0] === 11'd12 && launch_page[0] === 6'd9, "R7 final overrides",
        {launch_block[0], launch_page[0]}, {11'd12, 6'd9});
    busy_for(AC, "R8 busy d");
  endtask

  task automatic t_mix;
    prog(3, 0, 8'h11); busy_for(QB, "R11 busy a");
    cmd(8'h60);
    chk(queued === 2'b00, "R11 program queue dropped", queued, 0);
    row(5, 0, 1'b0); cmd(8'hD0);
    chk(launch_erase === 2'b10 && launch_prog === 2'b00, "R11 erase only", launch_erase, 2);
    busy_for(AC, "R8 busy e");
  endtask

  task automatic t_busy_ignore;
    prog(14, 2, 8'h11);
    cmd(8'h80);
    chk(cache_clr === 1'b0 && queued === 2'b01, "R9 setup ignored", {cache_clr, queued}, 1);
    cmd(8'h60);
    chk(queued === 2'b01 && busy === 1'b1, "R9 erase ignored", queued, 1);
    @(negedge clk);
    chk(busy === 1'b0 && queued === 2'b01, "R9 queue kept", queued, 1);
    prog(16, 2, 8'h10);
    chk(launch_prog === 2'b01 && launch_block[0] === 11'd16, "R7 after ignore",
        launch_block[0], 16);
    busy_for(AC, "R8 busy f");
  endtask

  initial begin : wdog
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; addr_valid = 1'b0;
    cmd_code = '0; addr_byte = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_single;
    t_two_prog;
    t_erase;
    t_replace;
    t_override;
    t_mix;
    t_busy_ignore;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule